// File: doc/BRIEF.md
# SPI Status and Data Register Interface

This block is the register layer a processor sees in front of an 8-bit serial shift engine. It has a small control register, a status register carrying three flags, and a data register. A write to the data register loads the shift engine. A read of the data register returns a receive buffer, which holds the last completed byte. A simple shift engine is included so that transfers can run. In master mode it shifts one bit per clock. In slave mode it shifts one bit per pulse on an external tick input.

Each flag clears through a two-step sequence. First the status register must be read while the flag is set. Then a specific access must follow: a data access for the completion and collision flags, or a control write for the mode-fault flag. While the completion flag is set and has not yet been seen by a status read, data writes are dropped. An interrupt request follows the completion flag, gated by an enable bit.

The register map is as follows. Control is at address 0: bit 0 is the interrupt enable and bit 1 selects master mode. Status is at address 1. Data is at address 2. Address 3 reads as zero. Read data is a combinational mux of the addressed register. Side effects happen only on the clock edge where `bus_valid` is high.

The three flags are each tracked by a small state machine with these states:
- `FLG_CLEAR`: the flag is low.
- `FLG_RAISED`: the flag is set but has not yet been seen by a status read.
- `FLG_ARMED`: the flag is set and has been seen by a status read.

Its transitions are:
- `FLG_CLEAR`→`FLG_RAISED` on a set event.
- `FLG_RAISED`→`FLG_ARMED` on a status read.
- `FLG_ARMED`→`FLG_CLEAR` on the flag's clearing access.
- `FLG_ARMED`→`FLG_RAISED` when the clearing access and a new set event occur in the same cycle.

The shift engine has these states:
- `ENG_IDLE`: no transfer.
- `ENG_SHIFT`: a transfer is in progress.
- `ENG_DONE`: a one-cycle completion pulse.

Its transitions are:
- `ENG_IDLE`→`ENG_SHIFT` on an accepted master-mode write, or on a slave tick (which also shifts the first bit).
- `ENG_SHIFT`→`ENG_DONE` on the eighth shift step.
- `ENG_DONE`→`ENG_IDLE` unconditionally.

Top module: `spi_regif`

## Requirements
- R1: The status register reads with the completion flag at bit 7, the write-collision flag at bit 6 and the mode-fault flag at bit 4. Bits 5 and 3..0 always read 0.
- R2: After reset, the status, control and data registers all read 0, and the interrupt request is low.
- R3: The completion flag sets when the eighth bit has shifted, in both master and slave modes. A master transfer makes the flag visible after the 9th clock edge following the edge that accepted the write.
- R4: The interrupt request is high exactly while the completion flag is set and control bit 0 is 1.
- R5: The completion flag clears only through this sequence: a status read made while the flag is set, followed by a later data-register read or write. A data access without that earlier status read leaves the flag set.
- R6: While the completion flag is set and has not been seen by a status read, a data write is dropped: the shift register is not loaded and no transfer starts. After such a status read, a data write is accepted.
- R7: The write-collision flag clears only through this sequence: a status read made while it is set, followed by a later data access.
- R8: A pulse on `mode_fault_in` sets the mode-fault flag. It clears only through this sequence: a status read made while it is set, followed by a later control write. Data accesses do not clear it.
- R9: An accepted data write starts a transfer only when control bit 1 (master) is 1. In slave mode the write only loads the shift register, and the transfer runs on 8 `slv_bit_tick` pulses.
- R10: A data read returns the receive buffer. The buffer is loaded with the shift register contents when a transfer completes while the completion flag is low. Bits shift MSB first, with `ser_out` showing the shift register MSB.
- R11: A transfer that completes while the completion flag is already set leaves the receive buffer unchanged, so the new byte is dropped.
- R12: An accepted data write during a transfer sets the write-collision flag and leaves the shift register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| slv_bit_tick | input | 1 | One-cycle pulse per bit in slave mode |
| mode_fault_in | input | 1 | One-cycle pulse reporting a mode fault |
| ser_in | input | 1 | Serial data into the shift register LSB |
| ser_out | output | 1 | Serial data from the shift register MSB |

## Verification
The assertions assume the following about the block's inputs:
- `bus_valid` is a single-cycle strobe.
- A slave tick never coincides with a data write.
- The master bit is not changed while a transfer runs.

Otherwise the engine could see a load and a shift step in the same cycle, or switch its stepping source mid-byte. The stimulus respects these assumptions by issuing one access per cycle. It changes control only while the engine is idle and spaces the tick pulses apart from all bus traffic. Mode-fault pulses are injected only while no flag sequence is half done.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [1:0] {
        FLG_CLEAR  = 2'd0,
        FLG_RAISED = 2'd1,
        FLG_ARMED  = 2'd2
    } flag_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_DONE  = 2'd2
    } eng_state_e;

    // register addresses
    localparam int REG_CTRL   = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_DATA   = 2;

    // control bit positions
    localparam int CTRL_IEN_BIT = 0;
    localparam int CTRL_MST_BIT = 1;

    // flag indices
    localparam int NUM_FLAGS  = 3;
    localparam int FIDX_DONE  = 0;
    localparam int FIDX_COLL  = 1;
    localparam int FIDX_FAULT = 2;

endpackage

// File: rtl/spi_flag_seq.sv
module spi_flag_seq
    import spi_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o,
    output logic unread_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (set_i) begin
                    state_d = FLG_RAISED;
                end
            end
            FLG_RAISED: begin
                if (arm_i) begin
                    state_d = FLG_ARMED;
                end
            end
            FLG_ARMED: begin
                if (clr_i) begin
                    state_d = set_i ? FLG_RAISED : FLG_CLEAR;
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o   = (state_q != FLG_CLEAR);
        unread_o = (state_q == FLG_RAISED);
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              master_i,
    input  logic              tick_i,
    input  logic              ser_in_i,
    output logic              ser_out_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] shreg_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    eng_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              step;

    // one bit per clock in master mode, one per tick in slave mode
    always_comb begin
        step = master_i ? 1'b1 : tick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (load_i) begin
                    if (master_i) begin
                        state_d = ENG_SHIFT;
                    end
                end else if (!master_i && tick_i) begin
                    state_d = ENG_SHIFT;
                end
            end
            ENG_SHIFT: begin
                if (step && cnt_q == LAST_BIT) begin
                    state_d = ENG_DONE;
                end
            end
            ENG_DONE: state_d = ENG_IDLE;
            default:  state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (load_i) begin
                        sh_q  <= load_data_i;
                        cnt_q <= '0;
                    end else if (!master_i && tick_i) begin
                        sh_q  <= {sh_q[DATA_W-2:0], ser_in_i};
                        cnt_q <= CNT_W'(1);
                    end
                end
                ENG_SHIFT: begin
                    if (step) begin
                        sh_q <= {sh_q[DATA_W-2:0], ser_in_i};
                        if (cnt_q != LAST_BIT) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        busy_o    = (state_q != ENG_IDLE);
        done_o    = (state_q == ENG_DONE);
        ser_out_o = sh_q[DATA_W-1];
        shreg_o   = sh_q;
    end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              slv_bit_tick,
    input  logic              mode_fault_in,
    input  logic              ser_in,
    output logic              ser_out
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);
    localparam int STS_DONE_BIT  = DATA_W - 1;
    localparam int STS_COLL_BIT  = DATA_W - 2;
    localparam int STS_FAULT_BIT = DATA_W - 4;

    // access decode
    logic sts_rd, data_acc, data_wr, ctrl_wr;
    logic wr_accept, eng_load;

    // control register
    logic ctrl_ien, ctrl_master;

    // flags
    logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q, flg_unread;

    // engine side
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_shreg;
    logic [DATA_W-1:0] rx_buf;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        sts_rd   = bus_valid && !bus_write && (bus_addr == A_STATUS);
        data_acc = bus_valid && (bus_addr == A_DATA);
        data_wr  = data_acc && bus_write;
        ctrl_wr  = bus_valid && bus_write && (bus_addr == A_CTRL);
        // a data write is dropped while completion is set and not yet seen
        wr_accept = data_wr && !flg_unread[FIDX_DONE];
        eng_load  = wr_accept && !eng_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_ien    <= 1'b0;
            ctrl_master <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_ien    <= bus_wdata[CTRL_IEN_BIT];
            ctrl_master <= bus_wdata[CTRL_MST_BIT];
        end
    end

    always_comb begin
        flg_set              = '0;
        flg_clr              = '0;
        flg_set[FIDX_DONE]   = eng_done;
        flg_clr[FIDX_DONE]   = data_acc;
        flg_set[FIDX_COLL]   = wr_accept && eng_busy;
        flg_clr[FIDX_COLL]   = data_acc;
        flg_set[FIDX_FAULT]  = mode_fault_in;
        flg_clr[FIDX_FAULT]  = ctrl_wr;
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        spi_flag_seq u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (flg_set[gi]),
            .arm_i    (sts_rd),
            .clr_i    (flg_clr[gi]),
            .flag_o   (flg_q[gi]),
            .unread_o (flg_unread[gi])
        );
    end

    spi_shift_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (eng_load),
        .load_data_i (bus_wdata),
        .master_i    (ctrl_master),
        .tick_i      (slv_bit_tick),
        .ser_in_i    (ser_in),
        .ser_out_o   (ser_out),
        .busy_o      (eng_busy),
        .done_o      (eng_done),
        .shreg_o     (eng_shreg)
    );

    // receive buffer: filled only when the completion flag is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf <= '0;
        end else if (eng_done && !flg_q[FIDX_DONE]) begin
            rx_buf <= eng_shreg;
        end
    end

    always_comb begin
        status_word                = '0;
        status_word[STS_DONE_BIT]  = flg_q[FIDX_DONE];
        status_word[STS_COLL_BIT]  = flg_q[FIDX_COLL];
        status_word[STS_FAULT_BIT] = flg_q[FIDX_FAULT];
        ctrl_word                  = '0;
        ctrl_word[CTRL_IEN_BIT]    = ctrl_ien;
        ctrl_word[CTRL_MST_BIT]    = ctrl_master;
    end

    always_comb begin
        if (bus_addr == A_CTRL) begin
            bus_rdata = ctrl_word;
        end else if (bus_addr == A_STATUS) begin
            bus_rdata = status_word;
        end else if (bus_addr == A_DATA) begin
            bus_rdata = rx_buf;
        end else begin
            bus_rdata = '0;
        end
        irq = flg_q[FIDX_DONE] && ctrl_ien;
    end

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
    import spi_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic                 data_acc,
    input logic                 data_wr,
    input logic                 ctrl_wr,
    input logic                 ctrl_master,
    input logic                 slv_bit_tick,
    input logic [NUM_FLAGS-1:0] flg_q,
    input logic [NUM_FLAGS-1:0] flg_unread,
    input logic                 eng_busy,
    input logic                 eng_done,
    input logic [DATA_W-1:0]    rx_buf
);

    a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flg_q[FIDX_DONE]);

    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flg_q[FIDX_DONE]);

    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[FIDX_DONE] && !data_acc) |=> flg_q[FIDX_DONE]);

    a_r6_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && flg_unread[FIDX_DONE] && !eng_busy && !slv_bit_tick) |=> !eng_busy);

    a_r7_coll_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[FIDX_COLL] && !data_acc) |=> flg_q[FIDX_COLL]);

    a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[FIDX_FAULT] && !ctrl_wr) |=> flg_q[FIDX_FAULT]);

    a_r9_master_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !flg_unread[FIDX_DONE] && !eng_busy && ctrl_master) |=> eng_busy);

    a_r9_slave_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !eng_busy && !ctrl_master && !slv_bit_tick) |=> !eng_busy);

    a_r11_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && flg_q[FIDX_DONE]) |=> $stable(rx_buf));

    a_r12_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !flg_unread[FIDX_DONE] && eng_busy) |=> flg_q[FIDX_COLL]);

endmodule

bind spi_regif spi_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .data_acc     (data_acc),
    .data_wr      (data_wr),
    .ctrl_wr      (ctrl_wr),
    .ctrl_master  (ctrl_master),
    .slv_bit_tick (slv_bit_tick),
    .flg_q        (flg_q),
    .flg_unread   (flg_unread),
    .eng_busy     (eng_busy),
    .eng_done     (eng_done),
    .rx_buf       (rx_buf)
);

// File: tb/spi_regif_tb.sv
module spi_regif_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v = 1'b0, w = 1'b0;
    logic [1:0] a = 2'd0;
    logic [7:0] d = 8'd0;
    logic [7:0] rdata;
    logic       irq, ser_out, ser_in;
    logic       tick = 1'b0, fault = 1'b0, lb = 1'b1, ext = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign ser_in = lb ? ser_out : ext;

    spi_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(v), .bus_write(w), .bus_addr(a),
        .bus_wdata(d), .bus_rdata(rdata), .irq(irq), .slv_bit_tick(tick),
        .mode_fault_in(fault), .ser_in(ser_in), .ser_out(ser_out)
    );

    // ---------------- behavioural reference ----------------
    bit       m_ien, m_mst;
    bit       m_fl[3], m_seen[3];
    int       m_est, m_cnt;
    bit [7:0] m_sh, m_rx;

    task automatic upd(input int i, input bit s, input bit rd, input bit c);
        if (!m_fl[i]) begin
            if (s) begin m_fl[i] = 1; m_seen[i] = 0; end
        end else if (!m_seen[i]) begin
            if (rd) m_seen[i] = 1;
        end else if (c) begin
            if (s) m_seen[i] = 0;
            else begin m_fl[i] = 0; m_seen[i] = 0; end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ien = 0; m_mst = 0; m_est = 0; m_cnt = 0; m_sh = 0; m_rx = 0;
            for (int i = 0; i < 3; i++) begin m_fl[i] = 0; m_seen[i] = 0; end
        end else begin
            bit s_rd, d_acc, d_wr, c_wr, acc, busy, done, sin;
            s_rd  = v && !w && a == 2'd1;
            d_acc = v && a == 2'd2;
            d_wr  = d_acc && w;
            c_wr  = v && w && a == 2'd0;
            acc   = d_wr && !(m_fl[0] && !m_seen[0]);
            busy  = m_est != 0;
            done  = m_est == 2;
            sin   = lb ? m_sh[7] : ext;
            if (done && !m_fl[0]) m_rx = m_sh;
            upd(0, done, s_rd, d_acc);
            upd(1, acc && busy, s_rd, d_acc);
            upd(2, fault, s_rd, c_wr);
            if (m_est == 0) begin
                if (acc) begin
                    m_sh = d; m_cnt = 0;
                    if (m_mst) m_est = 1;
                end else if (!m_mst && tick) begin
                    m_sh = {m_sh[6:0], sin}; m_cnt = 1; m_est = 1;
                end
            end else if (m_est == 1) begin
                if (m_mst || tick) begin
                    m_sh = {m_sh[6:0], sin};
                    if (m_cnt == 7) m_est = 2; else m_cnt++;
                end
            end else begin
                m_est = 0;
            end
            if (c_wr) begin m_ien = d[0]; m_mst = d[1]; end
        end
    end

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [7:0] exp;
            case (a)
                2'd0:    exp = {6'b0, m_mst, m_ien};
                2'd1:    exp = {m_fl[0], m_fl[1], 1'b0, m_fl[2], 4'b0};
                2'd2:    exp = m_rx;
                default: exp = 8'h00;
            endcase
            chk("R1/R10 model rdata", rdata, exp);
            chk("R4 model irq", {7'b0, irq}, {7'b0, m_fl[0] && m_ien});
            chk("R10 model ser_out", {7'b0, ser_out}, {7'b0, m_sh[7]});
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [1:0] ad, input logic wr, input logic [7:0] wd,
                       output logic [7:0] q);
        v = 1'b1; w = wr; a = ad; d = wd;
        #1 q = rdata;
        @(negedge clk);
        v = 1'b0; w = 1'b0;
    endtask

    task automatic peek(input logic [1:0] ad, output logic [7:0] q);
        a = ad;
        #1 q = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick8();
        repeat (8) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            summary();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] q;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        peek(2'd1, q); chk("R2 status after reset", q, 8'h00);
        peek(2'd0, q); chk("R2 control after reset", q, 8'h00);
        peek(2'd2, q); chk("R2 data after reset", q, 8'h00);
        chk("R2 irq after reset", {7'b0, irq}, 8'h00);

        // master transfer, loopback
        bus(2'd0, 1, 8'h03, q);
        bus(2'd2, 1, 8'hA5, q);
        idle(4);
        peek(2'd1, q); chk("R3 flag low mid transfer", q, 8'h00);
        idle(8);
        peek(2'd1, q); chk("R3 R1 flag after master transfer", q, 8'h80);
        chk("R4 irq with enable", {7'b0, irq}, 8'h01);
        bus(2'd0, 1, 8'h02, q);
        chk("R4 irq masked", {7'b0, irq}, 8'h00);
        bus(2'd0, 1, 8'h03, q);

        // locked write, then data read without status read
        bus(2'd2, 1, 8'h3C, q);
        idle(12);
        chk("R6 locked write leaves shift msb", {7'b0, ser_out}, 8'h01);
        bus(2'd2, 0, 8'h00, q); chk("R10 data read returns buffer", q, 8'hA5);
        peek(2'd1, q); chk("R5 flag held without status read", q, 8'h80);

        // status read unlocks the write
        bus(2'd1, 0, 8'h00, q); chk("R1 status read value", q, 8'h80);
        bus(2'd2, 1, 8'h42, q);
        peek(2'd1, q); chk("R5 flag cleared by sequence", q, 8'h00);
        idle(12);
        peek(2'd2, q); chk("R6 accepted write after status read", q, 8'h42);
        bus(2'd1, 0, 8'h00, q);
        bus(2'd2, 0, 8'h00, q);

        // write collision
        bus(2'd2, 1, 8'h96, q);
        bus(2'd2, 1, 8'h11, q);
        peek(2'd1, q); chk("R12 collision flag set", q, 8'h40);
        idle(12);
        peek(2'd1, q); chk("R1 two flags", q, 8'hC0);
        bus(2'd1, 0, 8'h00, q);
        bus(2'd2, 0, 8'h00, q); chk("R12 shift register kept first byte", q, 8'h96);
        peek(2'd1, q); chk("R7 collision cleared", q, 8'h00);

        // slave mode: load only
        bus(2'd0, 1, 8'h01, q);
        bus(2'd2, 1, 8'h5A, q);
        idle(12);
        peek(2'd1, q); chk("R9 slave write does not start", q, 8'h00);
        chk("R9 slave write loads shift register", {7'b0, ser_out}, 8'h00);
        tick8();
        idle(3);
        peek(2'd1, q); chk("R3 slave completion", q, 8'h80);
        peek(2'd2, q); chk("R10 slave received byte", q, 8'h5A);

        // overrun
        lb = 1'b0; ext = 1'b1;
        tick8();
        idle(3);
        peek(2'd2, q); chk("R11 overrun keeps first byte", q, 8'h5A);
        bus(2'd1, 0, 8'h00, q);
        bus(2'd2, 0, 8'h00, q);
        peek(2'd1, q); chk("R5 cleared after overrun", q, 8'h00);
        ext = 1'b0;
        tick8();
        idle(3);
        peek(2'd2, q); chk("R10 next byte loads buffer", q, 8'h00);
        bus(2'd1, 0, 8'h00, q);
        bus(2'd2, 0, 8'h00, q);
        lb = 1'b1;

        // mode fault
        fault = 1'b1; @(negedge clk); fault = 1'b0;
        peek(2'd1, q); chk("R8 R1 fault flag", q, 8'h10);
        bus(2'd0, 1, 8'h01, q);
        peek(2'd1, q); chk("R8 ctrl write without status read", q, 8'h10);
        bus(2'd1, 0, 8'h00, q);
        bus(2'd2, 0, 8'h00, q);
        peek(2'd1, q); chk("R8 data access does not clear", q, 8'h10);
        bus(2'd0, 1, 8'h01, q);
        peek(2'd1, q); chk("R8 fault cleared", q, 8'h00);
        chk("R4 irq low at end", {7'b0, irq}, 8'h00);

        idle(2);
        summary();
    end

endmodule